// File: doc/BRIEF.md
# Serial Sync Word Detector

This block watches a demodulated serial bit stream that arrives one bit per strobe of a recovered data clock enable. Each accepted bit is shifted into a history register, and after every shift the most recent bits are compared with a programmed sync pattern of one to four bytes. When the number of disagreeing bits is no larger than a programmed tolerance, the block raises a one-cycle match pulse and sets a sticky interrupt flag that stays set until it is cleared.

The detector runs only while recognition is enabled and the upstream bit synchronizer reports that it is active. Dropping either qualifier, or applying the synchronous reset, empties the history so that a fresh window has to be collected before a match can be reported. The pattern is a plain 32-bit input holding four bytes, so the same configuration value can also feed a transmit-side sync generator elsewhere in the chip.

Top module: `sync_word_detector`

## Requirements
- R1: A match pulse is produced only when both `det_en` and `bitsync_on` are 1. Whenever either is 0 at a clock edge, the history and the accepted-bit count are cleared.
- R2: The comparison is re-evaluated after every accepted bit and every window that meets the tolerance gives a pulse, including windows that overlap a previous match.
- R3: `size_sel` values 0, 1, 2 and 3 select windows of 8, 16, 24 and 32 bits (1 to 4 pattern bytes).
- R4: A match is declared when the number of mismatching bits in the window is less than or equal to `tol_sel` (0 to 3).
- R5: Pattern byte k sits at `pattern[8k+7:8k]`. The earliest bit of the window is compared with bit 7 of byte 0, and the latest bit with bit 0 of byte `size_sel`; bits in between follow the same order.
- R6: Pattern bytes above byte `size_sel`, and received bits older than the window, have no effect on the result.
- R7: No match is reported until at least the window length in bits has been accepted since the last reset or activation.
- R8: The match pulse is high for exactly one clock cycle, the cycle after the clock edge that accepted the completing bit.
- R9: `irq_flag` is set in the same cycle as a match pulse and stays set until `irq_clr` is 1 at a clock edge; a match at the same edge as a clear leaves the flag set.
- R10: A synchronous reset (`rst` = 1) clears the history, the bit count, the match pulse and the interrupt flag.
- R11: Cycles with `bit_valid` = 0 shift no bit and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| det_en | input | 1 | Sync recognition enable |
| bitsync_on | input | 1 | Bit synchronizer active qualifier |
| bit_valid | input | 1 | Strobe marking a received bit |
| bit_in | input | 1 | Received data bit |
| size_sel | input | 2 | Window length select, (size_sel+1) bytes |
| tol_sel | input | 2 | Number of tolerated bit errors |
| pattern | input | 32 | Sync pattern, byte k at bits 8k+7..8k |
| irq_clr | input | 1 | Clear for the sticky interrupt flag |
| match_pulse | output | 1 | One-cycle match indication |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The two functions that can meet in one cycle are the setting of the sticky flag by a new match and its clearing by `irq_clr`. The bench raises `irq_clr` at the very edge that accepts the completing bit of a matching window and expects the flag to remain set with the pulse present, then clears again with no match pending and expects the flag low. Separately, the enable qualifiers are dropped between bits so that a pending window is discarded at the same edge as a strobe would have completed it, and the bench judges that no pulse follows until a full new window arrives.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;

    localparam int unsigned BYTE_BITS = 8;

    // Window length in bits for a byte-count selector value.
    function automatic int unsigned win_len(input int unsigned sel);
        return (sel + 1) * BYTE_BITS;
    endfunction

endpackage

// File: rtl/sync_hist_shifter.sv
module sync_hist_shifter #(
    parameter int unsigned WIN_W = 32,
    parameter int unsigned CNT_W = $clog2(WIN_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [WIN_W-1:0] hist_nxt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             shift_nxt
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_W);

    typedef struct packed {
        logic [WIN_W-1:0] hist;
        logic [CNT_W-1:0] cnt;
    } shreg_t;

    shreg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        shift_nxt = 1'b0;
        if (!active) begin
            st_d.hist = '0;
            st_d.cnt  = '0;
        end else if (bit_valid) begin
            shift_nxt = 1'b1;
            st_d.hist = {st_q.hist[WIN_W-2:0], bit_in};
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_nxt = st_d.hist;
    assign cnt_nxt  = st_d.cnt;

endmodule

// File: rtl/sync_pattern_align.sv
module sync_pattern_align #(
    parameter int unsigned BYTES  = 4,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned SIZE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [BYTES*BYTE_W-1:0] pattern,
    input  logic [SIZE_W-1:0]       size_sel,
    output logic [BYTES*BYTE_W-1:0] ref_vec,
    output logic [BYTES*BYTE_W-1:0] ref_mask
);

    localparam int unsigned WIN_W = BYTES * BYTE_W;

    logic [WIN_W-1:0] cand_vec  [BYTES];
    logic [WIN_W-1:0] cand_mask [BYTES];

    // One candidate per selectable length: byte 0 lands in the most
    // significant used byte, the last used byte in the lowest one.
    for (genvar s = 0; s < BYTES; s++) begin : g_len
        for (genvar k = 0; k < BYTES; k++) begin : g_byte
            if (k <= s) begin : g_used
                assign cand_vec[s][(s-k)*BYTE_W +: BYTE_W]  = pattern[k*BYTE_W +: BYTE_W];
            end else begin : g_unused
                assign cand_vec[s][k*BYTE_W +: BYTE_W]      = '0;
            end
            if (k <= s) begin : g_mon
                assign cand_mask[s][k*BYTE_W +: BYTE_W] = '1;
            end else begin : g_moff
                assign cand_mask[s][k*BYTE_W +: BYTE_W] = '0;
            end
        end
    end

    always_comb begin
        ref_vec  = cand_vec[0];
        ref_mask = cand_mask[0];
        for (int s = 0; s < BYTES; s++) begin
            if (int'(size_sel) == s) begin
                ref_vec  = cand_vec[s];
                ref_mask = cand_mask[s];
            end
        end
    end

endmodule

// File: rtl/sync_err_counter.sv
module sync_err_counter #(
    parameter int unsigned WIN_W = 32,
    parameter int unsigned CNT_W = $clog2(WIN_W + 1)
) (
    input  logic [WIN_W-1:0] hist,
    input  logic [WIN_W-1:0] ref_vec,
    input  logic [WIN_W-1:0] ref_mask,
    output logic [CNT_W-1:0] err_cnt
);

    logic [WIN_W-1:0] diff;

    assign diff = (hist ^ ref_vec) & ref_mask;

    always_comb begin
        err_cnt = '0;
        for (int i = 0; i < WIN_W; i++) begin
            err_cnt = err_cnt + CNT_W'(diff[i]);
        end
    end

endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector #(
    parameter int unsigned BYTES  = 4,
    parameter int unsigned TOL_W  = 2,
    parameter int unsigned SIZE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       det_en,
    input  logic                       bitsync_on,
    input  logic                       bit_valid,
    input  logic                       bit_in,
    input  logic [SIZE_W-1:0]          size_sel,
    input  logic [TOL_W-1:0]           tol_sel,
    input  logic [BYTES*sync_det_pkg::BYTE_BITS-1:0] pattern,
    input  logic                       irq_clr,
    output logic                       match_pulse,
    output logic                       irq_flag
);

    import sync_det_pkg::*;

    localparam int unsigned WIN_W = BYTES * BYTE_BITS;
    localparam int unsigned CNT_W = $clog2(WIN_W + 1);

    typedef struct packed {
        logic match;
        logic irq;
    } out_t;

    out_t out_d, out_q;

    logic             active;
    logic [WIN_W-1:0] hist_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             shift_nxt;
    logic [WIN_W-1:0] ref_vec;
    logic [WIN_W-1:0] ref_mask;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] need_bits;
    logic             hit;

    assign active = det_en & bitsync_on;

    sync_hist_shifter #(
        .WIN_W (WIN_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .hist_nxt  (hist_nxt),
        .cnt_nxt   (cnt_nxt),
        .shift_nxt (shift_nxt)
    );

    sync_pattern_align #(
        .BYTES  (BYTES),
        .BYTE_W (BYTE_BITS),
        .SIZE_W (SIZE_W)
    ) u_align (
        .pattern  (pattern),
        .size_sel (size_sel),
        .ref_vec  (ref_vec),
        .ref_mask (ref_mask)
    );

    sync_err_counter #(
        .WIN_W (WIN_W),
        .CNT_W (CNT_W)
    ) u_errs (
        .hist     (hist_nxt),
        .ref_vec  (ref_vec),
        .ref_mask (ref_mask),
        .err_cnt  (err_cnt)
    );

    assign need_bits = CNT_W'(win_len(int'(size_sel)));

    assign hit = shift_nxt && (cnt_nxt >= need_bits)
              && (err_cnt <= CNT_W'(tol_sel));

    always_comb begin
        out_d       = out_q;
        out_d.match = hit;
        // a new match outranks a clear in the same cycle
        out_d.irq   = (out_q.irq & ~irq_clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign match_pulse = out_q.match;
    assign irq_flag    = out_q.irq;

endmodule

// File: rtl/sync_word_detector_chk.sv
module sync_word_detector_chk #(
    parameter int unsigned BYTES  = 4,
    parameter int unsigned TOL_W  = 2,
    parameter int unsigned SIZE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              det_en,
    input logic              bitsync_on,
    input logic              bit_valid,
    input logic [SIZE_W-1:0] size_sel,
    input logic              irq_clr,
    input logic              match_pulse,
    input logic              irq_flag
);

    localparam int unsigned WIN_W = BYTES * sync_det_pkg::BYTE_BITS;

    int unsigned seen_q;

    always_ff @(posedge clk) begin
        if (rst || !(det_en && bitsync_on)) begin
            seen_q <= 0;
        end else if (bit_valid && seen_q < WIN_W) begin
            seen_q <= seen_q + 1;
        end
    end

    // R1 R11
    qualified_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> $past(bit_valid && det_en && bitsync_on));

    // R7
    full_window_chk: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (seen_q >= (int'($past(size_sel)) + 1) * sync_det_pkg::BYTE_BITS));

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> irq_flag);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(irq_flag) && !$past(rst)) |-> $past(irq_clr));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_clr) && !$past(rst) && !match_pulse) |-> !irq_flag);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!match_pulse && !irq_flag));

endmodule

bind sync_word_detector sync_word_detector_chk #(
    .BYTES  (BYTES),
    .TOL_W  (TOL_W),
    .SIZE_W (SIZE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .det_en      (det_en),
    .bitsync_on  (bitsync_on),
    .bit_valid   (bit_valid),
    .size_sel    (size_sel),
    .irq_clr     (irq_clr),
    .match_pulse (match_pulse),
    .irq_flag    (irq_flag)
);

// File: tb/sync_word_detector_test.sv
module sync_word_detector_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        det_en = 1'b0;
    logic        bitsync_on = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic [1:0]  tol_sel = 2'd0;
    logic [31:0] pattern = 32'h5DE239B4;
    logic        irq_clr = 1'b0;
    logic        match_pulse;
    logic        irq_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_hist = '0;
    int          m_cnt = 0;
    logic        m_irq = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_word_detector uut (
        .clk         (clk),
        .rst         (rst),
        .det_en      (det_en),
        .bitsync_on  (bitsync_on),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .size_sel    (size_sel),
        .tol_sel     (tol_sel),
        .pattern     (pattern),
        .irq_clr     (irq_clr),
        .match_pulse (match_pulse),
        .irq_flag    (irq_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic lfsr_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Window position i (0 = earliest) against pattern byte i/8, bit 7-(i%8).
    function automatic logic pat_bit(input int i);
        return pattern[(i / 8) * 8 + 7 - (i % 8)];
    endfunction

    function automatic bit model_match();
        int n = 8 * (int'(size_sel) + 1);
        int err = 0;
        if (m_cnt < n) return 1'b0;
        for (int i = 0; i < n; i++) begin
            if (pat_bit(i) != m_hist[n - 1 - i]) err++;
        end
        return err <= int'(tol_sel);
    endfunction

    task automatic send_bit(input logic b, input logic clr, input string tag);
        bit exp;
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        irq_clr   = clr;
        if (det_en && bitsync_on) begin
            m_hist = {m_hist[30:0], b};
            if (m_cnt < 32) m_cnt++;
            exp = model_match();
        end else begin
            m_hist = '0;
            m_cnt  = 0;
            exp    = 1'b0;
        end
        m_irq = (m_irq & ~clr) | exp;
        @(negedge clk);
        bit_valid = 1'b0;
        irq_clr   = 1'b0;
        check(match_pulse == exp, tag, match_pulse, exp);
        check(irq_flag == m_irq, {tag, " R9 flag"}, irq_flag, m_irq);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(match_pulse == 1'b0, tag, match_pulse, 0);
        end
    endtask

    task automatic set_active(input logic en, input logic bs);
        @(negedge clk);
        det_en     = en;
        bitsync_on = bs;
        if (!(en && bs)) begin
            m_hist = '0;
            m_cnt  = 0;
        end
        @(negedge clk);
        check(match_pulse == 1'b0, "R1 no pulse on mode change", match_pulse, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_hist = '0;
        m_cnt  = 0;
        m_irq  = 1'b0;
        check(match_pulse == 1'b0, "R10 pulse cleared", match_pulse, 0);
        check(irq_flag == 1'b0, "R10 flag cleared", irq_flag, 0);
    endtask

    task automatic send_window(input int n, input int e, input string tag);
        for (int i = 0; i < n; i++) begin
            logic b = pat_bit(i);
            for (int k = 0; k < e; k++) begin
                if (i == (k * 5 + 1) % n) b = ~b;
            end
            send_bit(b, 1'b0, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        @(negedge clk);
        @(negedge clk);
        check(match_pulse == 1'b0, "R10 reset pulse", match_pulse, 0);
        check(irq_flag == 1'b0, "R10 reset flag", irq_flag, 0);
        rst = 1'b0;
        set_active(1'b1, 1'b1);

        // R3 R4 R5 R6 R7: sweep length, tolerance and injected errors
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                for (int e = 0; e < 5; e++) begin
                    size_sel = 2'(s);
                    tol_sel  = 2'(t);
                    set_active(1'b0, 1'b1);
                    set_active(1'b1, 1'b1);
                    send_window(8 * (s + 1), e, "R3 R4 R5 R7 sweep");
                    for (int k = 0; k < 3; k++) send_bit(lfsr_bit(), 1'b0, "R6 R2 tail");
                    irq_clr = 1'b1;
                    @(negedge clk);
                    irq_clr = 1'b0;
                    m_irq = 1'b0;
                    check(irq_flag == 1'b0, "R9 cleared", irq_flag, 0);
                end
            end
        end

        // R2: overlapping matches with an alternating byte
        pattern  = 32'h0F33C3AA;
        size_sel = 2'd0;
        tol_sel  = 2'd0;
        set_active(1'b0, 1'b1);
        set_active(1'b1, 1'b1);
        for (int k = 0; k < 20; k++) send_bit(logic'(k % 2 == 0), 1'b0, "R2 overlap");

        // R6: unused pattern bytes changed, result must follow byte 0 only
        pattern = 32'hFFFF00AA;
        for (int k = 0; k < 6; k++) send_bit(logic'(k % 2 == 0), 1'b0, "R6 unused bytes");

        // R1: each qualifier alone blocks detection and clears the window
        set_active(1'b0, 1'b1);
        for (int k = 0; k < 10; k++) send_bit(logic'(k % 2 == 0), 1'b0, "R1 det_en low");
        set_active(1'b1, 1'b0);
        for (int k = 0; k < 10; k++) send_bit(logic'(k % 2 == 0), 1'b0, "R1 bitsync low");
        set_active(1'b1, 1'b1);
        for (int k = 0; k < 10; k++) send_bit(logic'(k % 2 == 0), 1'b0, "R1 R7 restart");

        // R9: clear at the same edge as a completing match keeps the flag
        pattern  = 32'h5DE239B4;
        size_sel = 2'd1;
        set_active(1'b0, 1'b1);
        set_active(1'b1, 1'b1);
        for (int i = 0; i < 15; i++) send_bit(pat_bit(i), 1'b0, "R9 prefix");
        send_bit(pat_bit(15), 1'b1, "R9 set beats clear");
        idle(3, "R8 single cycle pulse");
        check(irq_flag == 1'b1, "R9 sticky", irq_flag, 1);
        send_bit(1'b0, 1'b1, "R9 clear no match");

        // R10: reset mid-window discards history
        for (int i = 0; i < 10; i++) send_bit(pat_bit(i), 1'b0, "R10 prefix");
        do_reset();
        set_active(1'b1, 1'b1);
        for (int i = 10; i < 16; i++) send_bit(pat_bit(i), 1'b0, "R10 R7 after reset");

        // R11 R2: random stream with gaps and embedded patterns
        for (int r = 0; r < 40; r++) begin
            size_sel = 2'(r % 4);
            tol_sel  = 2'((r / 4) % 4);
            for (int k = 0; k < 12; k++) begin
                send_bit(lfsr_bit(), 1'b0, "R11 random");
                if (lfsr[1]) idle(int'(lfsr[3:2]), "R11 gap");
            end
            send_window(8 * (r % 4 + 1), r % 3, "R2 embedded");
            send_window(8 * (r % 4 + 1), 0, "R2 repeat");
            if (r % 5 == 0) begin
                irq_clr = 1'b1;
                @(negedge clk);
                irq_clr = 1'b0;
                m_irq = 1'b0;
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule